// File: doc/BRIEF.md
# Quaternary Four-Digit ALU

This block is a purely combinational arithmetic and logic unit for operands made of radix-4 digits. Each digit is held as a 2-bit code for the values 0 to 3, with digit i in bits [2i+1:2i]. Because of that layout, an operand vector read as an unsigned binary number equals its base-4 value, so four digits span 0 to 255.

A 3-bit select picks one of six result sources. Addition and subtraction ripple a carry digit through a chain of identical one-digit slices. Subtraction complements every subtrahend digit to 3 − d and adds a +1 to the lowest complemented digit, not to the carry-in. The lowest slice can therefore see an addend of 4, and a slice sum can reach 8, which gives a carry digit of 2. Digit-wise maximum, minimum and inversion work on each digit on its own. The spare codes drive zeros. No clock or state is involved.

Top module: `qalu`

## Requirements
- R1: With op_sel = 0 (add), result = (A + B + c) mod 256 and carry_out = (A + B + c) div 256, where c is the effective carry-in.
- R2: With op_sel = 1 (subtract), result = (A + 256 − B + c) mod 256 and carry_out = (A + 256 − B + c) div 256. This equals A − B + c when there is no borrow, with carry_out = 1.
- R3: Subtract with A = 255 (all digits 3), B = 0 and c = 1 gives result 0 and carry_out = 2.
- R4: With op_sel = 2, each result digit is the larger of the A and B digits in that position.
- R5: With op_sel = 3, each result digit is the smaller of the A and B digits in that position.
- R6: With op_sel = 4, each result digit is 3 minus the A digit, and B has no effect on the outputs.
- R7: With op_sel = 5, 6 or 7, result is all zero and carry_out is 0 for any operands.
- R8: For op_sel 2 to 7, carry_out is 0.
- R9: The effective carry-in c is 1 whenever carry_in is nonzero (codes 1, 2 and 3) and 0 for code 0.
- R10: Outputs depend only on the present inputs, and for all-zero inputs result and carry_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | Operand A, four 2-bit digits, least significant digit in bits [1:0] |
| opnd_b | input | 8 | Operand B, same layout |
| carry_in | input | 2 | Carry into the lowest slice; any nonzero code counts as 1 |
| op_sel | input | 3 | 0 add, 1 subtract, 2 maximum, 3 minimum, 4 invert A, 5 to 7 zero |
| result | output | 8 | Four result digits |
| carry_out | output | 2 | Carry/borrow digit out of the top slice (0, 1 or 2) |

## Verification
The bench targets the lowest subtract slice at its limit, A = 3333, B = 0 and a carry-in of 1. A slice that keeps only one carry bit would report a carry of 0 instead of 2. It also drives carry_in codes 2 and 3, where a design that passed the raw code into the chain would add 2 or 3. Digit-wise operations are driven with operands whose digits alternate in order, which exposes a maximum or minimum computed on the whole word instead of per digit. The spare select codes are driven with busy operands, which exposes leakage from a neighbouring source.

// File: rtl/qalu.sv
module qalu #(
  parameter int DIGITS = 4
) (
  input  logic [2*DIGITS-1:0] opnd_a,
  input  logic [2*DIGITS-1:0] opnd_b,
  input  logic [1:0]          carry_in,
  input  logic [2:0]          op_sel,
  output logic [2*DIGITS-1:0] result,
  output logic [1:0]          carry_out
);
  localparam int W = 2 * DIGITS;
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_MAX = 3'd2;
  localparam logic [2:0] OP_MIN = 3'd3;
  localparam logic [2:0] OP_INV = 3'd4;

  logic                is_sub;
  logic [2*DIGITS+1:0] chain;

  assign is_sub      = (op_sel == OP_SUB);
  assign chain[1:0]  = {1'b0, |carry_in};

  for (genvar g = 0; g < DIGITS; g++) begin : g_slice
    logic [1:0] da, db, dbc, sum_d, max_d, min_d, inv_d;
    logic [2:0] addend;
    logic [3:0] s;

    assign da    = opnd_a[2*g +: 2];
    assign db    = opnd_b[2*g +: 2];
    assign dbc   = 2'd3 - db;
    assign addend = is_sub ? ({1'b0, dbc} + ((g == 0) ? 3'd1 : 3'd0)) : {1'b0, db};
    assign s     = {2'b00, da} + {1'b0, addend} + {2'b00, chain[2*g +: 2]};
    assign sum_d = s[1:0];
    assign chain[2*g+2 +: 2] = s[3:2];
    assign max_d = (da >= db) ? da : db;
    assign min_d = (da <= db) ? da : db;
    assign inv_d = 2'd3 - da;

    always_comb begin
      case (op_sel)
        OP_ADD, OP_SUB: result[2*g +: 2] = sum_d;
        OP_MAX:         result[2*g +: 2] = max_d;
        OP_MIN:         result[2*g +: 2] = min_d;
        OP_INV:         result[2*g +: 2] = inv_d;
        default:        result[2*g +: 2] = 2'd0;
      endcase
    end
  end

  assign carry_out = (op_sel == OP_ADD || is_sub) ? chain[W +: 2] : 2'd0;
endmodule

// File: rtl/qalu_chk.sv
module qalu_chk #(
  parameter int DIGITS = 4
) (
  input logic [2*DIGITS-1:0] opnd_a,
  input logic [2*DIGITS-1:0] opnd_b,
  input logic [1:0]          carry_in,
  input logic [2:0]          op_sel,
  input logic [2*DIGITS-1:0] result,
  input logic [1:0]          carry_out
);
  logic unused_cin;
  assign unused_cin = ^carry_in;

  always_comb begin
    if (op_sel >= 3'd2) AST_LOGIC_NO_CARRY: assert (carry_out == 2'd0); // R8
    if (op_sel == 3'd0) AST_ADD_CARRY_RANGE: assert (carry_out <= 2'd1); // R1
    if (op_sel == 3'd1) AST_SUB_CARRY_RANGE: assert (carry_out != 2'd3); // R2
    if (op_sel >= 3'd5) AST_SPARE_ZERO: assert (result == '0); // R7
    for (int i = 0; i < DIGITS; i++) begin
      if (op_sel == 3'd2)
        AST_MAX_BOUND: assert (result[2*i +: 2] >= opnd_a[2*i +: 2] && result[2*i +: 2] >= opnd_b[2*i +: 2]); // R4
      if (op_sel == 3'd3)
        AST_MIN_BOUND: assert (result[2*i +: 2] <= opnd_a[2*i +: 2] && result[2*i +: 2] <= opnd_b[2*i +: 2]); // R5
      if (op_sel == 3'd4)
        AST_INV_PAIR: assert ({1'b0, result[2*i +: 2]} + {1'b0, opnd_a[2*i +: 2]} == 3'd3); // R6
    end
  end
endmodule

bind qalu qalu_chk #(.DIGITS(DIGITS)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .op_sel(op_sel),
  .result(result), .carry_out(carry_out)
);

// File: tb/test_qalu.sv
module test_qalu;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] a, b, res;
  logic [1:0] cin, cout;
  logic [2:0] op;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  qalu i_qalu (.opnd_a(a), .opnd_b(b), .carry_in(cin), .op_sel(op), .result(res), .carry_out(cout));

  function automatic int digit(int v, int i);
    return (v / (4 ** i)) % 4;
  endfunction

  function automatic void model(int va, int vb, int c, int o, output int er, output int ec);
    int ce = (c != 0) ? 1 : 0;
    int t;
    er = 0; ec = 0;
    case (o)
      0: begin t = va + vb + ce; er = t % 256; ec = t / 256; end
      1: begin t = va + 256 - vb + ce; er = t % 256; ec = t / 256; end
      2, 3, 4: begin
        for (int i = 0; i < 4; i++) begin
          int x = digit(va, i), y = digit(vb, i), d;
          if (o == 2) d = (x > y) ? x : y;
          else if (o == 3) d = (x < y) ? x : y;
          else d = 3 - x;
          er += d * (4 ** i);
        end
      end
      default: begin er = 0; ec = 0; end
    endcase
  endfunction

  task automatic run(int va, int vb, int c, int o, string req);
    int er, ec;
    @(posedge clk);
    a = va[7:0]; b = vb[7:0]; cin = c[1:0]; op = o[2:0];
    @(negedge clk);
    model(va, vb, c, o, er, ec);
    checks++;
    if (int'(res) != er || int'(cout) != ec) begin
      failures++;
      $display("FAIL %s op=%0d a=%0d b=%0d cin=%0d: actual res=%0d cout=%0d expected res=%0d cout=%0d",
               req, o, va, vb, c, res, cout, er, ec);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    a = 0; b = 0; cin = 0; op = 0;
    run(0, 0, 0, 0, "R10");
    run(255, 1, 0, 0, "R1");
    run(255, 255, 1, 0, "R1");
    run(27, 100, 0, 0, "R1");
    run(120, 45, 0, 1, "R2");
    run(45, 120, 1, 1, "R2");
    run(7, 7, 0, 1, "R2");
    run(255, 0, 1, 1, "R3");
    run(3, 0, 1, 1, "R3");
    run(8'b11_00_11_00, 8'b00_11_00_11, 0, 2, "R4");
    run(8'b01_10_00_11, 8'b10_01_11_00, 0, 3, "R5");
    run(8'b00_01_10_11, 0, 0, 4, "R6");
    run(8'b00_01_10_11, 255, 1, 4, "R6");
    run(255, 255, 3, 5, "R7");
    run(200, 17, 1, 6, "R7");
    run(170, 85, 2, 7, "R7");
    run(255, 200, 1, 2, "R8");
    run(10, 20, 2, 0, "R9");
    run(10, 20, 3, 1, "R9");
    run(255, 0, 2, 1, "R9");
    for (int n = 0; n < 16000; n++) begin
      int o = $urandom_range(7, 0);
      string r;
      case (o) 0: r = "R1"; 1: r = "R2"; 2: r = "R4"; 3: r = "R5"; 4: r = "R6"; default: r = "R7"; endcase
      run($urandom_range(255, 0), $urandom_range(255, 0), $urandom_range(3, 0), o, r);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule